// File: doc/BRIEF.md
# Palette Colour Lookup with Sequential RGB Access

This block stores a colour palette for a pseudocolour display path. It has 256 pixel entries and a separate bank of 4 overlay entries used for cursor colours. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. A host reaches the palette through a small 32-bit register window. It first writes an entry number. It then streams colour bytes, which the block places into the red, green and blue fields of that entry in turn. After each complete triplet the block moves on to the next entry by itself. Host reads walk through the same sequence. The colour byte always sits in the top byte of the 32-bit word.

A second, independent port serves the display pipeline. It takes a 9-bit entry number and returns the packed 24-bit colour at once, with no clock delay. This lets a pixel stream be mapped through the palette while the host is updating it.

Top module: `pal_dac`

## Requirements
- R1: A write to byte offset 0 loads the entry index from `wdata_i[31:24]` and returns the component sequencer to red.
- R2: Writes to offset 4 store into pixel entry `index`, taking the byte from `wdata_i[31:24]`. Successive writes go to red, then green, then blue.
- R3: Each access that completes a blue component increments the index modulo 256 (255 wraps to 0) and returns the sequencer to red. Red and green accesses leave the index unchanged.
- R4: Writes to offset 12 store into overlay entry `index[1:0]` (palette entry 256 + `index[1:0]`). They follow the same red, green, blue order and the same index advance as R2 and R3.
- R5: A read at offset 4 returns the current component of pixel entry `index` in bits 31:24, with bits 23:0 zero. A read at offset 12 does the same for overlay entry `index[1:0]`. Both kinds of read advance the sequencer exactly as writes do.
- R6: A read at offset 0 returns the index in bits 31:24, with the remaining bits zero. It has no side effect.
- R7: Writes and reads at any offset other than 0, 4 and 12 change no entry, leave the index and the sequencer alone, and such reads return zero. When `rd_en_i` is low, `rdata_o` is zero.
- R8: After reset all entries are zero except pixel entry 255 and overlay entries 0 and 2 (palette 256 and 258), which are 0xFFFFFF. The index is 0 and the sequencer is at red.
- R9: The lookup port returns `{red, green, blue}` (red in bits 23:16) combinationally. When `lut_idx_i[8]` is 0 it reads pixel entry `lut_idx_i[7:0]`; when it is 1 it reads overlay entry `lut_idx_i[1:0]`.
- R10: When `wr_en_i` and `rd_en_i` are high in the same cycle, the write takes effect and the read has no side effect on the index or the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 4 | Byte offset of the host access |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid while `rd_en_i` is high |
| lut_idx_i | input | 9 | Entry number for the display lookup |
| lut_rgb_o | output | 24 | Looked-up colour `{r,g,b}` |

## Verification
On every cycle, the bound checker verifies the sequencer and index bookkeeping. It checks that an index write loads the index and rewinds to red, and that only blue accesses move the index. It also checks that stray offsets and idle cycles leave the state untouched, and that read data keeps its low 24 bits zero. Whether colour bytes land in the right field of the right entry is shown only by the bench scenarios. These cover the reset contents, the wrap from 255 to 0, overlay aliasing through the low index bits, and colliding read and write strobes. The bench compares the lookup port and host reads against its own palette model.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned CW = 8;
  localparam int unsigned RGB_W = 3 * CW;

  typedef enum logic [1:0] {
    SEL_R = 2'd0,
    SEL_G = 2'd1,
    SEL_B = 2'd2
  } comp_sel_e;

  function automatic logic [CW-1:0] pick_comp(input logic [RGB_W-1:0] rgb, input comp_sel_e sel);
    case (sel)
      SEL_R:   pick_comp = rgb[3*CW-1 -: CW];
      SEL_G:   pick_comp = rgb[2*CW-1 -: CW];
      default: pick_comp = rgb[CW-1 -: CW];
    endcase
  endfunction
endpackage

// File: rtl/pal_bank.sv
module pal_bank
  import pal_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter logic [DEPTH-1:0] WHITE_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  comp_sel_e        wsel_i,
  input  logic [CW-1:0]    wbyte_i,
  input  logic [AW-1:0]    raddr_a_i,
  output logic [RGB_W-1:0] rgb_a_o,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [RGB_W-1:0] rgb_b_o
);
  logic [RGB_W-1:0] ent_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [RGB_W-1:0] RST_VAL = WHITE_MASK[i] ? '1 : '0;
    logic hit;
    assign hit = we_i && (waddr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= RST_VAL;
      end else if (hit) begin
        case (wsel_i)
          SEL_R:   ent_q[i][3*CW-1 -: CW] <= wbyte_i;
          SEL_G:   ent_q[i][2*CW-1 -: CW] <= wbyte_i;
          default: ent_q[i][CW-1 -: CW]   <= wbyte_i;
        endcase
      end
    end
  end

  assign rgb_a_o = ent_q[raddr_a_i];
  assign rgb_b_o = ent_q[raddr_b_i];
endmodule

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_ld_i,
  input  logic [IDX_W-1:0] idx_d_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output comp_sel_e        sel_o
);
  logic [IDX_W-1:0] idx_q;
  comp_sel_e        sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= SEL_R;
    end else if (idx_ld_i) begin
      idx_q <= idx_d_i;
      sel_q <= SEL_R;
    end else if (step_i) begin
      case (sel_q)
        SEL_R: sel_q <= SEL_G;
        SEL_G: sel_q <= SEL_B;
        default: begin
          sel_q <= SEL_R;
          idx_q <= idx_q + 1'b1;  // wraps at 2**IDX_W
        end
      endcase
    end
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/pal_dac.sv
module pal_dac
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OVL_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_IDX = 0,
  parameter int unsigned OFS_PIX = 4,
  parameter int unsigned OFS_OVL = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W:0]    lut_idx_i,
  output logic [RGB_W-1:0]  lut_rgb_o
);
  localparam int unsigned N_PIX = 1 << IDX_W;
  localparam int unsigned N_OVL = 1 << OVL_W;
  localparam int unsigned LOW_W = DATA_W - CW;
  localparam logic [N_PIX-1:0] PIX_WHITE = N_PIX'(1) << (N_PIX - 1);
  localparam logic [N_OVL-1:0] OVL_WHITE = N_OVL'(5);  // overlay 0 and 2

  logic             at_idx, at_pix, at_ovl;
  logic             wr_idx, wr_pix, wr_ovl, rd_pix, rd_ovl, step;
  logic [IDX_W-1:0] idx;
  comp_sel_e        sel;
  logic [CW-1:0]    wbyte;
  logic [RGB_W-1:0] pix_lut, pix_host, ovl_lut, ovl_host;

  assign at_idx = (addr_i == ADDR_W'(OFS_IDX));
  assign at_pix = (addr_i == ADDR_W'(OFS_PIX));
  assign at_ovl = (addr_i == ADDR_W'(OFS_OVL));

  assign wr_idx = wr_en_i && at_idx;
  assign wr_pix = wr_en_i && at_pix;
  assign wr_ovl = wr_en_i && at_ovl;
  // a colliding write owns the cycle
  assign rd_pix = rd_en_i && !wr_en_i && at_pix;
  assign rd_ovl = rd_en_i && !wr_en_i && at_ovl;
  assign step   = wr_pix || wr_ovl || rd_pix || rd_ovl;
  assign wbyte  = wdata_i[DATA_W-1 -: CW];

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_ld_i (wr_idx),
    .idx_d_i  (wbyte),
    .step_i   (step),
    .idx_o    (idx),
    .sel_o    (sel)
  );

  pal_bank #(.DEPTH(N_PIX), .AW(IDX_W), .WHITE_MASK(PIX_WHITE)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_pix),
    .waddr_i   (idx),
    .wsel_i    (sel),
    .wbyte_i   (wbyte),
    .raddr_a_i (lut_idx_i[IDX_W-1:0]),
    .rgb_a_o   (pix_lut),
    .raddr_b_i (idx),
    .rgb_b_o   (pix_host)
  );

  pal_bank #(.DEPTH(N_OVL), .AW(OVL_W), .WHITE_MASK(OVL_WHITE)) u_ovl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_ovl),
    .waddr_i   (idx[OVL_W-1:0]),
    .wsel_i    (sel),
    .wbyte_i   (wbyte),
    .raddr_a_i (lut_idx_i[OVL_W-1:0]),
    .rgb_a_o   (ovl_lut),
    .raddr_b_i (idx[OVL_W-1:0]),
    .rgb_b_o   (ovl_host)
  );

  assign lut_rgb_o = lut_idx_i[IDX_W] ? ovl_lut : pix_lut;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (at_idx)      rdata_o = {idx, LOW_W'(0)};
      else if (at_pix) rdata_o = {pick_comp(pix_host, sel), LOW_W'(0)};
      else if (at_ovl) rdata_o = {pick_comp(ovl_host, sel), LOW_W'(0)};
    end
  end
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [IDX_W-1:0]  idx,
  input logic [1:0]        sel
);
  logic known, data_acc, any_acc;
  assign known    = (addr_i == 0) || (addr_i == 4) || (addr_i == 12);
  assign data_acc = (wr_en_i || rd_en_i) && ((addr_i == 4) || (addr_i == 12));
  assign any_acc  = wr_en_i && (addr_i == 0) || data_acc;

  assert_idx_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == 0 |=> idx == $past(wdata_i[DATA_W-1 -: IDX_W]) && sel == 2'd0);

  assert_blue_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && sel == 2'd2 |=> idx == $past(idx) + 1'b1 && sel == 2'd0);

  assert_rg_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && sel != 2'd2 |=> $stable(idx) && sel == $past(sel) + 2'd1);

  assert_stray_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !known |-> rdata_o == '0);

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

  assert_no_side_effect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_acc |=> $stable(idx) && $stable(sel));

  assert_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-IDX_W-1:0] == '0);

  assert_idx_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == 0 |-> rdata_o[DATA_W-1 -: IDX_W] == idx);

  assert_sel_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel != 2'd3);
endmodule

bind pal_dac pal_dac_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .idx     (idx),
  .sel     (sel)
);

// File: tb/pal_dac_tb.sv
module pal_dac_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [23:0] m_ent [260];
  logic [7:0]  m_idx;
  int          m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_dac u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .lut_idx_i(lut_idx), .lut_rgb_o(lut_rgb)
  );

  function automatic int ent_of(input logic [3:0] a, input logic [7:0] i);
    return (a == 4'd12) ? 256 + int'(i[1:0]) : int'(i);
  endfunction

  function automatic logic [7:0] comp_of(input logic [23:0] c, input int s);
    return (s == 0) ? c[23:16] : (s == 1) ? c[15:8] : c[7:0];
  endfunction

  function automatic logic [31:0] exp_rdata(input logic w, input logic r, input logic [3:0] a);
    if (!r) return 32'h0;
    if (a == 4'd0) return {m_idx, 24'h0};
    if (a == 4'd4 || a == 4'd12) return {comp_of(m_ent[ent_of(a, m_idx)], m_sel), 24'h0};
    return 32'h0;
  endfunction

  task automatic model_step(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    bit data_acc;
    data_acc = (a == 4'd4 || a == 4'd12) && (w || r);
    if (w && a == 4'd0) begin
      m_idx = d[31:24]; m_sel = 0;
    end else if (data_acc) begin
      if (w) begin
        int e;
        e = ent_of(a, m_idx);
        case (m_sel)
          0: m_ent[e][23:16] = d[31:24];
          1: m_ent[e][15:8]  = d[31:24];
          default: m_ent[e][7:0] = d[31:24];
        endcase
      end
      if (m_sel == 2) begin m_sel = 0; m_idx = m_idx + 8'd1; end
      else m_sel = m_sel + 1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one bus cycle; rdata checked mid-cycle, state updates at the next posedge
  task automatic bus(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) check(req, rdata, exp_rdata(w, r, a));
    @(posedge clk);
    model_step(w, r, a, d);
    #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic look(input int e, input string req);
    @(negedge clk);
    lut_idx = 9'(e);
    #1;
    check(req, {8'h0, lut_rgb}, {8'h0, m_ent[e >= 256 ? 256 + (e & 3) : e]});
  endtask

  task automatic wr_rgb(input logic [3:0] a, input logic [23:0] c);
    bus(1, 0, a, {c[23:16], 24'h0}, "R2");
    bus(1, 0, a, {c[15:8], 24'h0}, "R2");
    bus(1, 0, a, {c[7:0], 24'h0}, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 260; i++) m_ent[i] = 24'h0;
    m_ent[255] = 24'hFFFFFF; m_ent[256] = 24'hFFFFFF; m_ent[258] = 24'hFFFFFF;
    m_idx = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R8: reset contents, index and sequencer
    for (int e = 0; e < 260; e++) look(e, "R8");
    bus(0, 1, 4'd0, 32'h0, "R8");
    bus(0, 1, 4'd4, 32'h0, "R8");

    // R1 + R2 + R9: directed pixel write and readback
    bus(1, 0, 4'd0, 32'h1A00_0000, "R1");
    bus(0, 1, 4'd0, 32'h0, "R1");
    wr_rgb(4'd4, 24'h123456);
    look(8'h1A, "R9");
    bus(0, 1, 4'd0, 32'h0, "R3");

    // R3: wrap 255 -> 0
    bus(1, 0, 4'd0, 32'hFF00_0000, "R1");
    wr_rgb(4'd4, 24'hA1B2C3);
    look(255, "R3");
    bus(0, 1, 4'd0, 32'h0, "R3");

    // R1: index write mid-triplet rewinds to red
    bus(1, 0, 4'd0, 32'h4000_0000, "R1");
    bus(1, 0, 4'd4, 32'h7700_0000, "R1");
    bus(1, 0, 4'd0, 32'h4000_0000, "R1");
    bus(0, 1, 4'd4, 32'h0, "R1");

    // R4: overlay aliasing via low index bits (index 6 -> entry 258)
    bus(1, 0, 4'd0, 32'h0600_0000, "R4");
    wr_rgb(4'd12, 24'h0F1E2D);
    look(258, "R4");
    look(6, "R4");
    look(9'h1FE, "R9");
    bus(0, 1, 4'd0, 32'h0, "R4");

    // R5: read sequence through pixel and overlay
    bus(1, 0, 4'd0, 32'h1A00_0000, "R5");
    for (int k = 0; k < 4; k++) bus(0, 1, 4'd4, 32'h0, "R5");
    bus(0, 1, 4'd0, 32'h0, "R5");
    bus(1, 0, 4'd0, 32'h0200_0000, "R5");
    for (int k = 0; k < 3; k++) bus(0, 1, 4'd12, 32'h0, "R5");

    // R7: stray offsets
    bus(1, 0, 4'd0, 32'h1A00_0000, "R7");
    bus(1, 0, 4'd8, 32'hEE00_0000, "R7");
    bus(1, 0, 4'd5, 32'hEE00_0000, "R7");
    bus(0, 1, 4'd8, 32'h0, "R7");
    bus(0, 1, 4'd0, 32'h0, "R7");
    bus(0, 1, 4'd4, 32'h0, "R7");
    look(8'h1A, "R7");

    // R10: colliding strobes
    bus(1, 0, 4'd0, 32'h3000_0000, "R10");
    bus(1, 1, 4'd8, 32'h0, "R10");
    bus(0, 1, 4'd0, 32'h0, "R10");
    bus(1, 1, 4'd4, 32'h5500_0000, "R10");
    bus(0, 1, 4'd4, 32'h0, "R10");
    look(8'h30, "R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [3:0] a;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 5))
        0: a = 4'd0;
        1, 2: a = 4'd4;
        3, 4: a = 4'd12;
        default: a = 4'($urandom_range(0, 15));
      endcase
      if (op < 4) bus(1, 0, a, $urandom, "R2");
      else if (op < 8) bus(0, 1, a, 32'h0, "R5");
      else if (op == 8) bus(1, 1, a, $urandom, "R10");
      else look($urandom_range(0, 259), "R9");
    end
    for (int e = 0; e < 260; e++) look(e, "R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule